// File: doc/BRIEF.md
# Table-Driven Tape Sequencer

This block is a small Turing machine for turning a slow stream of received pulse symbols into time-of-day values. It holds a tape of 256 four-bit cells and a head that steps up or down one cell at a time. It also holds an 8-bit machine state. On every step it forms a 17-bit lookup address from four parts: a bank bit, four configuration bits (zone offset, seasonal shift, display choice), the state, and the current input nibble. A transition memory outside the block answers with a 16-bit word. That word names the next state, an optional tape write, the head movement and where the next input comes from.

A step runs through four phases, sequenced by a 2-bit Johnson counter: read the input, present the lookup address, write the tape, then update the state and head. The input is either the tape cell under the head or a received 2-bit symbol. In the second case the machine waits in the read phase until a symbol strobe arrives. State 8'hFF stops the machine until reset. The lookup program sits entirely in the external memory, which has a one-cycle read latency. The same configuration switches can therefore change the decoding without any logic change.

Top module: `tm_seq`

## Requirements
- R1: After reset the state is 0, the head is 0, every tape cell reads 0, the input source is the tape, and `halted` and `waiting` are low.
- R2: With the tape as source, one step takes exactly four rising edges from the read phase. The new state and head are visible after the fourth edge, and the state never changes at any other edge.
- R3: `xlat_addr` is {bank (bit 16), cfg (bits 15:12), state (bits 11:4), input nibble (bits 3:0)}. It is valid in the cycle after the input is taken. The external memory answers on `xlat_rdata` one cycle after the address.
- R4: Word fields: [7:0] next state, [11:8] tape write data, [12] write enable, [13] direction (1 = up), [14] move enable, [15] next input source (1 = received stream, 0 = tape).
- R5: A tape write goes to the cell under the head before that step's move. A write and a move in the same word therefore leave the new value at the old head position.
- R6: The head changes by exactly one per moving step and wraps modulo 256 in both directions (0 down gives 255, 255 up gives 0).
- R7: With the stream as source, the machine holds in the read phase with `waiting` high and the state unchanged until `sym_valid` is seen. The input nibble is then {2'b00, sym}.
- R8: A `sym_valid` pulse outside the read phase has no effect, and its symbol is never used.
- R9: Once the state is 8'hFF, `halted` is high and the state, head and tape stay frozen whatever the inputs do.
- R10: The configuration and bank inputs reach the lookup address directly. Different settings select different transitions for the same state and input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bank_sel | input | 1 | High/low program bank |
| cfg | input | 4 | Configuration switches fed into the lookup address |
| sym_valid | input | 1 | Strobe marking a received symbol |
| sym | input | 2 | Received pulse symbol |
| xlat_addr | output | 17 | Address to the transition memory |
| xlat_rdata | input | 16 | Transition word, one cycle after the address |
| state_q | output | 8 | Current machine state |
| head_q | output | 8 | Current head position |
| cell_q | output | 4 | Tape cell under the head |
| halted | output | 1 | Machine stopped in state 8'hFF |
| waiting | output | 1 | Read phase stalled for a received symbol |

## Verification
A tape write and a head move land in the same step, and their order decides which cell holds the new value. One program alternates a write-and-move-up step with a move-down step without a write. The cell under the head after each return must equal the value the model wrote one step earlier. A second coincidence is a symbol strobe raised in the tape-write phase while the machine is already consuming a symbol. The bench sends a different symbol in that phase and judges by the cell written and the state reached, both of which must follow only the symbol accepted in the read phase.

// File: rtl/tm_seq.sv
module tm_seq #(
  parameter int HEAD_W = 8,
  parameter int SYM_W  = 4,
  parameter int ST_W   = 8,
  parameter int CFG_W  = 4,
  parameter int IN_W   = 2,
  localparam int DEPTH = 1 << HEAD_W,
  localparam int XA_W  = 1 + CFG_W + ST_W + SYM_W,
  localparam int XW_W  = ST_W + SYM_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bank_sel,
  input  logic [CFG_W-1:0]  cfg,
  input  logic              sym_valid,
  input  logic [IN_W-1:0]   sym,
  output logic [XA_W-1:0]   xlat_addr,
  input  logic [XW_W-1:0]   xlat_rdata,
  output logic [ST_W-1:0]   state_q,
  output logic [HEAD_W-1:0] head_q,
  output logic [SYM_W-1:0]  cell_q,
  output logic              halted,
  output logic              waiting
);
  localparam int F_WE  = ST_W + SYM_W;
  localparam int F_UP  = F_WE + 1;
  localparam int F_MV  = F_WE + 2;
  localparam int F_SRC = F_WE + 3;

  localparam logic [1:0] PH_RD = 2'b00;
  localparam logic [1:0] PH_LK = 2'b01;
  localparam logic [1:0] PH_WR = 2'b11;
  localparam logic [1:0] PH_UP = 2'b10;

  logic [1:0]       ph;
  logic [SYM_W-1:0] in_q;
  logic [XW_W-1:0]  word_q;
  logic             src_q;
  logic             adv;
  logic [SYM_W-1:0] tape [DEPTH];

  assign halted    = &state_q;
  assign waiting   = (ph == PH_RD) && src_q && !halted;
  assign adv       = !halted && ((ph != PH_RD) || !src_q || sym_valid);
  assign cell_q    = tape[head_q];
  assign xlat_addr = {bank_sel, cfg, state_q, in_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph      <= PH_RD;
      in_q    <= '0;
      word_q  <= '0;
      src_q   <= 1'b0;
      state_q <= '0;
      head_q  <= '0;
      for (int i = 0; i < DEPTH; i++) tape[i] <= '0;
    end else begin
      if (adv) ph <= {ph[0], ~ph[1]};
      if (adv && ph == PH_RD)
        in_q <= src_q ? SYM_W'(sym) : tape[head_q];
      if (ph == PH_WR) begin
        word_q <= xlat_rdata;
        if (xlat_rdata[F_WE]) tape[head_q] <= xlat_rdata[F_WE-1:ST_W];
      end
      if (ph == PH_UP) begin
        state_q <= word_q[ST_W-1:0];
        src_q   <= word_q[F_SRC];
        if (word_q[F_MV])
          head_q <= word_q[F_UP] ? head_q + HEAD_W'(1) : head_q - HEAD_W'(1);
      end
    end
  end

  // R2
  state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_UP) |=> $stable(state_q));

  // R6
  head_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (head_q != $past(head_q)) |->
      ((head_q == $past(head_q) + HEAD_W'(1)) || (head_q == $past(head_q) - HEAD_W'(1))));

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && !sym_valid) |=> (waiting && $stable(state_q)));

  // R9
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(state_q) && $stable(head_q) && $stable(cell_q)));
endmodule

// File: tb/tb_tm_seq.sv
module tb_tm_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bank_sel = 1'b0;
  logic [3:0]  cfg = 4'd0;
  logic        sym_valid = 1'b0;
  logic [1:0]  sym = 2'd0;
  logic [16:0] xlat_addr;
  logic [15:0] xlat_rdata;
  logic [7:0]  state_q, head_q;
  logic [3:0]  cell_q;
  logic        halted, waiting;

  int total = 0;
  int bad = 0;
  int mode = 0;

  logic [3:0] tape_m [256];
  logic [7:0] st_m, hd_m;
  logic       src_m;

  always #5 clk = ~clk;

  tm_seq dut (
    .clk(clk), .rst_n(rst_n), .bank_sel(bank_sel), .cfg(cfg),
    .sym_valid(sym_valid), .sym(sym), .xlat_addr(xlat_addr),
    .xlat_rdata(xlat_rdata), .state_q(state_q), .head_q(head_q),
    .cell_q(cell_q), .halted(halted), .waiting(waiting)
  );

  function automatic logic [15:0] prog(input logic [16:0] a);
    logic       b;
    logic [3:0] c, i;
    logic [7:0] s, ns;
    logic [3:0] wd;
    logic       we, up, mv, src;
    b = a[16]; c = a[15:12]; s = a[11:4]; i = a[3:0];
    ns = {1'b0, s[6:0] + 7'd1};
    wd = 4'd0; we = 1'b1; up = 1'b1; mv = 1'b1; src = 1'b0;
    case (mode)
      0: begin wd = i + c + 4'd1; up = b; end
      1: begin we = ~s[0]; wd = s[3:0] ^ i; up = ~s[0]; end
      2: begin we = ~s[0]; wd = i; up = ~s[0]; src = 1'b1; end
      default: begin ns = (s == 8'hC0) ? 8'hFF : s + 8'h40; wd = 4'hA; end
    endcase
    return {src, mv, up, we, wd, ns};
  endfunction

  always_ff @(posedge clk) xlat_rdata <= prog(xlat_addr);

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sym_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 256; k++) tape_m[k] = 4'd0;
    st_m = 8'd0; hd_m = 8'd0; src_m = 1'b0;
  endtask

  // starts and ends at a negedge in the read phase
  task automatic do_step(input logic [1:0] s, input int stall, input logic glitch);
    logic [3:0]  inp;
    logic [16:0] ea;
    logic [15:0] w;
    inp = src_m ? {2'b00, s} : tape_m[hd_m];
    ea = {bank_sel, cfg, st_m, inp};
    w = prog(ea);
    if (src_m) begin
      for (int k = 0; k < stall; k++) begin
        @(negedge clk);
        chk(waiting == 1'b1, "R7 waiting", waiting, 1);
        chk(state_q == st_m, "R7 stalled state", state_q, st_m);
      end
      sym = s; sym_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      sym_valid = 1'b0;
    end else begin
      @(posedge clk);
      @(negedge clk);
    end
    chk(xlat_addr == ea, "R3 lookup address", xlat_addr, ea);
    @(posedge clk);
    @(negedge clk);
    if (glitch) begin sym = ~s; sym_valid = 1'b1; end
    @(posedge clk);
    @(negedge clk);
    sym_valid = 1'b0;
    chk(state_q == st_m, "R2 state before last edge", state_q, st_m);
    @(posedge clk);
    @(negedge clk);
    if (w[12]) tape_m[hd_m] = w[11:8];
    if (w[14]) hd_m = w[13] ? hd_m + 8'd1 : hd_m - 8'd1;
    st_m = w[7:0];
    src_m = w[15];
    chk(state_q == st_m, "R4 next state", state_q, st_m);
    chk(head_q == hd_m, "R6 head", head_q, hd_m);
    chk(cell_q == tape_m[hd_m], "R5 cell under head", cell_q, tape_m[hd_m]);
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1 reset state
    bank_sel = 1'b1; cfg = 4'd5; mode = 0;
    do_reset();
    chk(state_q == 8'd0, "R1 state", state_q, 0);
    chk(head_q == 8'd0, "R1 head", head_q, 0);
    chk(cell_q == 4'd0, "R1 cell", cell_q, 0);
    chk(!halted && !waiting, "R1 flags", {halted, waiting}, 0);
    chk(xlat_addr == 17'h15000, "R3 reset address", xlat_addr, 17'h15000);

    // R10 sweep over configuration and bank, walking program
    for (int b = 0; b < 2; b++)
      for (int c = 0; c < 16; c++) begin
        bank_sel = b[0]; cfg = c[3:0]; mode = 0;
        do_reset();
        for (int n = 0; n < 6; n++) do_step(2'd0, 0, 1'b0);
        chk(head_q == (b[0] ? 8'd6 : 8'd250), "R10 R6 head after sweep", head_q, b[0] ? 6 : 250);
      end

    // R6 wrap upward past 255
    bank_sel = 1'b1; cfg = 4'd2; mode = 0;
    do_reset();
    for (int n = 0; n < 260; n++) do_step(2'd0, 0, 1'b0);
    chk(head_q == 8'd4, "R6 upward wrap", head_q, 4);

    // R5 write and move in one step, then return
    bank_sel = 1'b0; cfg = 4'd9; mode = 1;
    do_reset();
    for (int n = 0; n < 40; n++) do_step(2'd0, 0, 1'b0);

    // R7 R8 stream input with stalls and stray strobes
    cfg = 4'd3; mode = 2;
    do_reset();
    do_step(2'd0, 0, 1'b0);
    for (int n = 0; n < 24; n++) do_step(n[1:0] ^ 2'd1, n % 4, n[0]);

    // R9 halt
    cfg = 4'd1; mode = 3;
    do_reset();
    for (int n = 0; n < 4; n++) do_step(2'd0, 0, 1'b0);
    chk(halted == 1'b1, "R9 halted", halted, 1);
    for (int k = 0; k < 12; k++) begin
      sym_valid = k[0]; sym = k[1:0];
      @(negedge clk);
      chk(state_q == 8'hFF, "R9 frozen state", state_q, 8'hFF);
      chk(head_q == hd_m, "R9 frozen head", head_q, hd_m);
      chk(cell_q == tape_m[hd_m], "R9 frozen cell", cell_q, tape_m[hd_m]);
      chk(waiting == 1'b0, "R9 not waiting", waiting, 0);
    end
    sym_valid = 1'b0;

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule